// File: doc/BRIEF.md
# Converter Offset Calibration Sequencer

This block is the digital side of an offset calibration for an analog-to-digital converter. Software pulses a start request while the converter is disabled. The block then powers the analog macro up, asks it to run its offset measurement, and takes the 7-bit correction the macro returns. It files that correction into one of two stored fields, one for single-ended conversions and one for differential conversions. Last, it powers the macro back down. A status bit reads 1 from acceptance to the end of the sequence and clears itself in hardware. Conversion control must treat that bit as a lockout.

The two stored corrections are kept while the converter is disabled. A power-loss indication wipes them and abandons any sequence in progress. Software may then put a saved pair back through a write path. The block forwards each accepted write to the analog macro with a one-cycle load strobe.

Top module: `adc_cal_ctrl`

## Requirements
- R1: After reset, `calBusy`, `anaPowerReq`, `anaCalReq` and `anaFactLoad` are 0 and `factRd` reads all zeros.
- R2: A start request (`calStartWr` high for one cycle) is accepted only while `convEnable` is 0 and no sequence is running. A request while enabled leaves `calBusy` and `anaPowerReq` at 0. A request during a sequence does not restart it.
- R3: After an accepted start, `calBusy` reads 1 from the next cycle. `anaPowerReq` rises and `anaCalReq` stays low until `anaReady` is seen. `anaCalReq` holds until `anaDone` and is never high without `anaPowerReq`. `anaPowerReq` then falls, and `calBusy` clears once `anaReady` has dropped.
- R4: With the mode bit at 0 at acceptance, the returned value goes to `factRd[6:0]`. With it at 1, the value goes to `factRd[13:7]`. The other field keeps its value.
- R5: The mode is captured when the start is accepted. Changes to `calModeIn` during the sequence do not change `anaCalMode` or the field that is written.
- R6: Both stored fields keep their values while `convEnable` toggles.
- R7: `powerLost` high for a cycle clears both fields to zero. From the next cycle it also ends any sequence, with `calBusy`, `anaPowerReq` and `anaCalReq` at 0.
- R8: A factor write (`factWrEn`, data on `factWrData` with the same field layout as `factRd`) is accepted only while idle and `convEnable` is 1. Otherwise `factRd` is unchanged.
- R9: An accepted write updates `factRd` on the next cycle. In that same cycle `anaFactLoad` pulses high for one cycle with `anaFactOut` equal to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| calStartWr | input | 1 | One-cycle write of 1 to the start bit |
| calModeIn | input | 1 | Mode bit: 0 single-ended, 1 differential |
| convEnable | input | 1 | Converter enable bit |
| calBusy | output | 1 | Start bit readback, 1 while a sequence runs |
| factWrEn | input | 1 | Software write to the factor register |
| factWrData | input | 14 | Write data: [6:0] single-ended, [13:7] differential |
| factRd | output | 14 | Factor register readback, same layout |
| powerLost | input | 1 | Converter power removed |
| anaPowerReq | output | 1 | Power-up request to the analog macro |
| anaReady | input | 1 | Analog macro powered acknowledge |
| anaCalReq | output | 1 | Run-calibration request |
| anaCalMode | output | 1 | Captured mode for the running calibration |
| anaDone | input | 1 | Calibration done strobe |
| anaResult | input | 7 | Measured correction, valid with anaDone |
| anaFactLoad | output | 1 | One-cycle strobe loading anaFactOut into the macro |
| anaFactOut | output | 14 | Stored factor pair toward the macro |

## Verification
A sequencer stuck in a wrong state shows up at the ports within one cycle of the next handshake edge. Examples are `calBusy` failing to clear after the power-down, or `anaCalReq` appearing before the ready acknowledge. A wrongly captured mode is visible only once the sequence ends, when the correction lands in the wrong half of `factRd`. It is therefore checked after every run of a sweep over all 128 correction values in both modes. A lost power-loss clear or a misgated write shows on the next readback.

// File: rtl/calPkg.sv
package calPkg;
  localparam int FACT_W = 7;

  typedef enum logic [2:0] {
    CAL_IDLE,
    CAL_PWRUP,
    CAL_RUN,
    CAL_STORE,
    CAL_PWRDN
  } calState_t;

  typedef struct packed {
    logic capture;
    logic storeSingle;
    logic storeDiff;
    logic clearAll;
    logic swWrite;
  } calStrobe_t;
endpackage

// File: rtl/calCtrl.sv
module calCtrl
  import calPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startWr,
  input  logic       modeIn,
  input  logic       convEnable,
  input  logic       factWrEn,
  input  logic       powerLost,
  input  logic       anaReady,
  input  logic       anaDone,
  output calStrobe_t strobe,
  output logic       calBusy,
  output logic       powerReq,
  output logic       calReq,
  output logic       calMode
);
  calState_t state, stateNext;
  logic modeReg;
  logic startOk;

  assign startOk = (state == CAL_IDLE) && startWr && !convEnable && !powerLost;

  always_comb begin
    stateNext = state;
    unique case (state)
      CAL_IDLE:  if (startOk) stateNext = CAL_PWRUP;
      CAL_PWRUP: if (anaReady) stateNext = CAL_RUN;
      CAL_RUN:   if (anaDone) stateNext = CAL_STORE;
      CAL_STORE: stateNext = CAL_PWRDN;
      CAL_PWRDN: if (!anaReady) stateNext = CAL_IDLE;
      default:   stateNext = CAL_IDLE;
    endcase
    if (powerLost) stateNext = CAL_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= CAL_IDLE;
      modeReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (startOk) modeReg <= modeIn;
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.clearAll    = powerLost;
    strobe.capture     = (state == CAL_RUN) && anaDone && !powerLost;
    strobe.storeSingle = (state == CAL_STORE) && !modeReg;
    strobe.storeDiff   = (state == CAL_STORE) && modeReg;
    strobe.swWrite     = (state == CAL_IDLE) && factWrEn && convEnable && !powerLost;
  end

  assign calBusy  = (state != CAL_IDLE);
  assign powerReq = (state == CAL_PWRUP) || (state == CAL_RUN) || (state == CAL_STORE);
  assign calReq   = (state == CAL_RUN);
  assign calMode  = modeReg;

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!calBusy && startWr && convEnable) |=> !calBusy);
  // R3
  req_nested_chk: assert property (@(posedge clk) disable iff (!rstN)
    calReq |-> powerReq);
  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (calBusy && $past(calBusy)) |-> $stable(calMode));
  // R7
  abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerLost |=> (!calBusy && !powerReq));
endmodule

// File: rtl/calData.sv
module calData
  import calPkg::*;
#(
  parameter int FW = FACT_W,
  localparam int PAIR_W = 2 * FW
)(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strobe,
  input  logic [FW-1:0]     anaResult,
  input  logic [PAIR_W-1:0] factWrData,
  output logic [PAIR_W-1:0] factRd,
  output logic              factLoad
);
  logic [FW-1:0] singleF, diffF, resultHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      singleF    <= '0;
      diffF      <= '0;
      resultHold <= '0;
      factLoad   <= 1'b0;
    end else begin
      factLoad <= strobe.swWrite;
      if (strobe.capture) resultHold <= anaResult;
      if (strobe.clearAll) begin
        singleF <= '0;
        diffF   <= '0;
      end else if (strobe.swWrite) begin
        singleF <= factWrData[FW-1:0];
        diffF   <= factWrData[PAIR_W-1:FW];
      end else begin
        if (strobe.storeSingle) singleF <= resultHold;
        if (strobe.storeDiff)   diffF   <= resultHold;
      end
    end
  end

  assign factRd = {diffF, singleF};

  // R4
  single_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(singleF) |-> $past(strobe.storeSingle || strobe.swWrite || strobe.clearAll));
  // R4
  diff_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(diffF) |-> $past(strobe.storeDiff || strobe.swWrite || strobe.clearAll));
  // R7
  wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (factRd == '0));
endmodule

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl
  import calPkg::*;
#(
  parameter int FW = FACT_W,
  localparam int PAIR_W = 2 * FW
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              calStartWr,
  input  logic              calModeIn,
  input  logic              convEnable,
  output logic              calBusy,
  input  logic              factWrEn,
  input  logic [PAIR_W-1:0] factWrData,
  output logic [PAIR_W-1:0] factRd,
  input  logic              powerLost,
  output logic              anaPowerReq,
  input  logic              anaReady,
  output logic              anaCalReq,
  output logic              anaCalMode,
  input  logic              anaDone,
  input  logic [FW-1:0]     anaResult,
  output logic              anaFactLoad,
  output logic [PAIR_W-1:0] anaFactOut
);
  calStrobe_t strobe;

  calCtrl uCtrl (
    .clk(clk), .rstN(rstN), .startWr(calStartWr), .modeIn(calModeIn),
    .convEnable(convEnable), .factWrEn(factWrEn), .powerLost(powerLost),
    .anaReady(anaReady), .anaDone(anaDone), .strobe(strobe),
    .calBusy(calBusy), .powerReq(anaPowerReq), .calReq(anaCalReq),
    .calMode(anaCalMode)
  );

  calData #(.FW(FW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .anaResult(anaResult),
    .factWrData(factWrData), .factRd(factRd), .factLoad(anaFactLoad)
  );

  assign anaFactOut = factRd;

  // R9
  load_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    anaFactLoad |-> $past(factWrEn && convEnable && !calBusy));
endmodule

// File: tb/sim_adc_cal_ctrl.sv
`timescale 1ns/1ps
module sim_adc_cal_ctrl;
  logic clk = 0, rstN = 0;
  logic calStartWr = 0, calModeIn = 0, convEnable = 0, factWrEn = 0, powerLost = 0;
  logic [13:0] factWrData = '0;
  logic anaReady = 0, anaDone = 0;
  logic [6:0] anaResult = '0, stubValue = '0;
  logic calBusy, anaPowerReq, anaCalReq, anaCalMode, anaFactLoad;
  logic [13:0] factRd, anaFactOut;
  int checks = 0, fails = 0, doneCnt = 0;
  bit finished = 0;
  logic [6:0] expS = 0, expD = 0;

  always #2 clk = ~clk;

  adc_cal_ctrl u0 (
    .clk(clk), .rstN(rstN), .calStartWr(calStartWr), .calModeIn(calModeIn),
    .convEnable(convEnable), .calBusy(calBusy), .factWrEn(factWrEn),
    .factWrData(factWrData), .factRd(factRd), .powerLost(powerLost),
    .anaPowerReq(anaPowerReq), .anaReady(anaReady), .anaCalReq(anaCalReq),
    .anaCalMode(anaCalMode), .anaDone(anaDone), .anaResult(anaResult),
    .anaFactLoad(anaFactLoad), .anaFactOut(anaFactOut)
  );

  // analog stub: ready follows the power request, done three cycles into a run
  always @(negedge clk) begin
    anaReady <= anaPowerReq;
    if (anaCalReq) begin
      doneCnt   <= doneCnt + 1;
      anaDone   <= (doneCnt == 2);
      anaResult <= stubValue;
    end else begin
      doneCnt <= 0;
      anaDone <= 0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic pulseStart(logic mode);
    @(negedge clk);
    calModeIn  = mode;
    calStartWr = 1;
    @(negedge clk);
    calStartWr = 0;
  endtask

  // run one calibration; flipMode toggles the mode bit mid-sequence
  task automatic runCal(logic mode, logic [6:0] val, bit flipMode, bit deep);
    bit seqOk = 1, sawPower = 0, sawReq = 0;
    stubValue = val;
    pulseStart(mode);
    if (flipMode) calModeIn = ~mode;
    for (int i = 0; i < 60 && calBusy; i++) begin
      if (anaCalReq && !anaPowerReq) seqOk = 0;
      if (anaCalReq && !sawPower) seqOk = 0;
      if (anaPowerReq) sawPower = 1;
      if (anaCalReq) sawReq = 1;
      if (anaCalReq && anaCalMode !== mode) seqOk = 0;
      @(negedge clk);
    end
    if (mode) expD = val; else expS = val;
    if (deep) begin
      check("R3 handshake order", {seqOk, sawPower, sawReq}, 3'b111);
      check("R3 end state", {calBusy, anaPowerReq, anaCalReq}, 3'b000);
    end
    if (flipMode) check("R5 captured mode", factRd, {expD, expS});
    else check("R4 field routing", factRd, {expD, expS});
  endtask

  task automatic swWrite(logic [13:0] d);
    @(negedge clk);
    factWrData = d;
    factWrEn   = 1;
    @(negedge clk);
    factWrEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset outputs", {calBusy, anaPowerReq, anaCalReq, anaFactLoad}, 4'b0);
    check("R1 reset factors", factRd, 14'h0);
    rstN = 1;
    @(negedge clk);

    // R2: start while enabled is ignored
    convEnable = 1;
    pulseStart(0);
    check("R2 start while enabled", {calBusy, anaPowerReq}, 2'b00);
    convEnable = 0;

    // R3/R4 detailed runs
    runCal(0, 7'h55, 0, 1);
    runCal(1, 7'h2A, 0, 1);

    // R2: start during a sequence does not restart
    stubValue = 7'h11;
    pulseStart(1);
    @(negedge clk);
    calStartWr = 1;
    @(negedge clk);
    calStartWr = 0;
    for (int i = 0; i < 60 && calBusy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    expD = 7'h11;
    check("R2 no restart", {calBusy, factRd}, {1'b0, expD, expS});

    // R5: mode change mid sequence
    runCal(0, 7'h3C, 1, 0);
    runCal(1, 7'h4B, 1, 0);

    // R4 sweep over all values in both modes
    for (int v = 0; v < 256; v++) runCal(v[0], 7'((v >> 1) * 37 + 5), 0, 0);

    // R6 retention across enable toggles
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      convEnable = ~convEnable;
    end
    @(negedge clk);
    check("R6 retained", factRd, {expD, expS});

    // R8 write while disabled ignored
    convEnable = 0;
    swWrite(14'h1234);
    check("R8 write disabled", {anaFactLoad, factRd}, {1'b0, expD, expS});

    // R8/R9 accepted write
    convEnable = 1;
    @(negedge clk);
    factWrData = 14'h2ABC;
    factWrEn   = 1;
    @(negedge clk);
    factWrEn = 0;
    check("R9 load pulse", {anaFactLoad, anaFactOut}, {1'b1, 14'h2ABC});
    check("R8 write accepted", factRd, 14'h2ABC);
    @(negedge clk);
    check("R9 single cycle", anaFactLoad, 1'b0);
    {expD, expS} = 14'h2ABC;

    // R8 write during sequence ignored
    convEnable = 0;
    stubValue  = 7'h01;
    pulseStart(0);
    convEnable = 1;
    factWrData = 14'h0F0F;
    factWrEn   = 1;
    @(negedge clk);
    factWrEn = 0;
    check("R8 write busy", {anaFactLoad, factRd}, {1'b0, expD, expS});
    for (int i = 0; i < 60 && calBusy; i++) @(negedge clk);
    expS = 7'h01;
    convEnable = 0;
    check("R4 after busy write", factRd, {expD, expS});

    // R7 power loss aborts and wipes
    stubValue = 7'h7F;
    pulseStart(1);
    for (int i = 0; i < 20 && !anaCalReq; i++) @(negedge clk);
    powerLost = 1;
    @(negedge clk);
    powerLost = 0;
    check("R7 abort", {calBusy, anaPowerReq, anaCalReq}, 3'b000);
    check("R7 wipe", factRd, 14'h0);
    repeat (10) @(negedge clk);
    check("R7 stays idle", {calBusy, factRd}, 15'h0);

    // R9 restore after loss
    convEnable = 1;
    swWrite(14'h1357);
    check("R9 restore", {anaFactOut, factRd}, {14'h1357, 14'h1357});
    finish();
  end
endmodule